// File: doc/BRIEF.md
# Corrected Multi-Channel Pulse-Width Modulator Bank

This block drives a bank of pulse-width modulated pins, one per channel, from a dedicated PWM clock. Each channel keeps two registers: a 12-bit pulse width and a 6-bit correction factor. The correction factor scales the width, which lets the channels be matched to one another. All channels share one 12-bit period counter. Each period begins with every active channel going high on the same clock, and each channel then falls once the count reaches its own effective width.

A global output-enable gates the whole bank. When the bank goes from disabled to enabled, the period counter restarts, so the first period lines up with the enable event. New widths and corrections are written into shadow registers through parallel load strobes. They reach the compare logic only at the start of a period, so a period never switches partway through.

Top module: `pwm_bank`

## Requirements
- R1: The bank has NCH channels (default 48). Channel i takes its width from `width_data[12*i+11:12*i]` when `width_load` is high, and its correction from `corr_data[6*i+5:6*i]` when `corr_load` is high. The two loads are independent of each other.
- R2: After reset, and at any time the bank is disabled, every bit of `pwm_out` is 0. Width and correction loads do not change this.
- R3: While enabled, the period counter advances by one on each clock and wraps after 4096 clocks. Channel i is high for the first E counts of each period and low for the rest, where E = floor(W*(C+64)/128), capped at 4096.
- R4: An `enable_stb` while the bank is disabled starts a period at count 0 on the next clock. In that cycle every channel with a nonzero effective width is high at the same time.
- R5: A width or correction loaded during a period does not change that period's outputs. It takes effect from the next period start. Values loaded while the bank is disabled apply to the first period after enable.
- R6: A channel with width 0 stays low for the whole period. Width 4095 with correction 63 gives a high time of 4063 clocks.
- R7: An `enable_stb` while the bank is already enabled neither restarts nor disturbs the period.
- R8: `disable_stb` drives all outputs low from the next clock and stops the counter. When `disable_stb` and `enable_stb` are high in the same cycle, disable wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_load | input | 1 | Strobe that writes all width shadow registers |
| width_data | input | NCH*12 | Packed per-channel pulse widths |
| corr_load | input | 1 | Strobe that writes all correction shadow registers |
| corr_data | input | NCH*6 | Packed per-channel correction factors |
| enable_stb | input | 1 | Output-enable strobe |
| disable_stb | input | 1 | Output-disable strobe |
| pwm_out | output | NCH | Per-channel PWM pins |

## Verification
The widths are tried in three patterns: a ramp, a descending pattern, and a pattern that keeps the widths but changes every correction. Each pattern always includes channel 0 at width zero and the last channel at full width. Comparing the high count per channel over one whole period separates a wrong scaling formula from a wrong compare edge. Checking that the high cycles form a contiguous run from count 0 shows any misplaced period start. Loads, enables and disables are also applied halfway through a measured period. These runs tell apart shadow registers that pass values straight through, a counter restarted by a redundant enable, and a disable that loses to a simultaneous enable.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Scaled width: w * (c + 2^cw) / 2^(cw+1), capped at the period length.
  function automatic int unsigned scaled_width(
    input int unsigned w,
    input int unsigned c,
    input int unsigned corr_w,
    input int unsigned cnt_w
  );
    int unsigned prod;
    int unsigned eff;
    int unsigned cap;
    prod = w * (c + (32'd1 << corr_w));
    eff  = prod >> (corr_w + 1);
    cap  = 32'd1 << cnt_w;
    if (eff > cap) eff = cap;
    return eff;
  endfunction

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_stb,
  input  logic             disable_stb,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             load_now
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (disable_stb) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (enable_stb && !run) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Active widths follow shadows while idle, and refresh at each wrap.
  assign load_now = !run || (cnt == LAST);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W  = 12,
  parameter int CORR_W = 6,
  localparam int EFF_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              width_we,
  input  logic [CNT_W-1:0]  width_in,
  input  logic              corr_we,
  input  logic [CORR_W-1:0] corr_in,
  input  logic              load_now,
  input  logic              run,
  input  logic [CNT_W-1:0]  cnt,
  output logic [EFF_W-1:0]  eff_q,
  output logic              pwm
);
  logic [CNT_W-1:0]  shadow_w;
  logic [CORR_W-1:0] shadow_c;
  logic [EFF_W-1:0]  eff_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_w <= '0;
      shadow_c <= '0;
    end else begin
      if (width_we) shadow_w <= width_in;
      if (corr_we)  shadow_c <= corr_in;
    end
  end

  assign eff_next = EFF_W'(pwm_bank_pkg::scaled_width(32'(shadow_w), 32'(shadow_c),
                                                      32'(CORR_W), 32'(CNT_W)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        eff_q <= '0;
    else if (load_now) eff_q <= eff_next;
  end

  assign pwm = run && ({1'b0, cnt} < eff_q);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 48,
  parameter int CNT_W  = 12,
  parameter int CORR_W = 6,
  localparam int EFF_W = CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  width_load,
  input  logic [NCH*CNT_W-1:0]  width_data,
  input  logic                  corr_load,
  input  logic [NCH*CORR_W-1:0] corr_data,
  input  logic                  enable_stb,
  input  logic                  disable_stb,
  output logic [NCH-1:0]        pwm_out
);
  logic                 period_run;
  logic [CNT_W-1:0]     period_cnt;
  logic                 period_load;
  logic [NCH*EFF_W-1:0] eff_bus;

  pwm_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_stb (enable_stb),
    .disable_stb(disable_stb),
    .run        (period_run),
    .cnt        (period_cnt),
    .load_now   (period_load)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .CORR_W(CORR_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .width_we(width_load),
      .width_in(width_data[i*CNT_W +: CNT_W]),
      .corr_we (corr_load),
      .corr_in (corr_data[i*CORR_W +: CORR_W]),
      .load_now(period_load),
      .run     (period_run),
      .cnt     (period_cnt),
      .eff_q   (eff_bus[i*EFF_W +: EFF_W]),
      .pwm     (pwm_out[i])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH   = 48,
  parameter int CNT_W = 12,
  parameter int EFF_W = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable_stb,
  input logic                 disable_stb,
  input logic                 period_run,
  input logic [CNT_W-1:0]     period_cnt,
  input logic                 period_load,
  input logic [NCH*EFF_W-1:0] eff_bus,
  input logic [NCH-1:0]       pwm_out
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !period_run |-> (pwm_out == '0));

  a_r3_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (period_run && $past(period_run)) |-> (period_cnt == CNT_W'($past(period_cnt) + 1'b1)));

  a_r4_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_run) |-> (period_cnt == '0));

  a_r5_widths_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !period_load |=> (eff_bus == $past(eff_bus)));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (period_run && enable_stb && !disable_stb) |=>
      (period_run && period_cnt == CNT_W'($past(period_cnt) + 1'b1)));

  a_r8_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    disable_stb |=> (!period_run && pwm_out == '0));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CNT_W(CNT_W), .EFF_W(EFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable_stb (enable_stb),
  .disable_stb(disable_stb),
  .period_run (period_run),
  .period_cnt (period_cnt),
  .period_load(period_load),
  .eff_bus    (eff_bus),
  .pwm_out    (pwm_out)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NCH = 48;
  localparam int CW  = 12;
  localparam int RW  = 6;
  localparam int PER = 4096;

  typedef struct { int ch; int exp; string tag; } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic width_load = 1'b0;
  logic [NCH*CW-1:0] width_data = '0;
  logic corr_load = 1'b0;
  logic [NCH*RW-1:0] corr_data = '0;
  logic enable_stb = 1'b0;
  logic disable_stb = 1'b0;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  sb_item_t sb_q[$];
  int wa[NCH], wb[NCH], ca[NCH], cc[NCH];

  always #5ns clk = ~clk;

  pwm_bank dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_eff(input int w, input int c);
    int e = (w * (c + 64)) / 128;
    return (e > PER) ? PER : e;
  endfunction

  task automatic drive_widths(input int w[NCH]);
    for (int i = 0; i < NCH; i++) width_data[i*CW +: CW] = CW'(w[i]);
    width_load = 1'b1;
  endtask

  task automatic drive_corrs(input int c[NCH]);
    for (int i = 0; i < NCH; i++) corr_data[i*RW +: RW] = RW'(c[i]);
    corr_load = 1'b1;
  endtask

  task automatic push_exp(input int w[NCH], input int c[NCH], input string tag);
    for (int i = 0; i < NCH; i++) begin
      sb_item_t it;
      it.ch = i; it.exp = model_eff(w[i], c[i]);
      it.tag = ((i == 0) || (i == NCH-1)) ? {tag, "/R6"} : tag;
      sb_q.push_back(it);
    end
  endtask

  // Starts just after a negedge at count 0; ends at the next period's count 0.
  // mid_op: 0 none, 1 load widths B, 2 redundant enable, 3 load corrections C
  task automatic measure(input int mid_op);
    int hi[NCH];
    int last[NCH];
    logic [NCH-1:0] first;
    for (int i = 0; i < NCH; i++) begin hi[i] = 0; last[i] = -1; end
    first = pwm_out;
    for (int s = 0; s < PER; s++) begin
      for (int i = 0; i < NCH; i++)
        if (pwm_out[i]) begin hi[i]++; last[i] = s; end
      if (s == 1000) begin
        if (mid_op == 1) drive_widths(wb);
        if (mid_op == 2) enable_stb = 1'b1;
        if (mid_op == 3) drive_corrs(cc);
      end
      @(negedge clk);
      width_load = 1'b0; corr_load = 1'b0; enable_stb = 1'b0;
    end
    for (int i = 0; i < NCH; i++) begin
      sb_item_t it = sb_q.pop_front();
      check(hi[it.ch] == it.exp && (it.exp == 0 || last[it.ch] == it.exp - 1),
            it.tag, hi[it.ch], it.exp);
      if (it.exp > 0) check(first[it.ch] == 1'b1, "R4 start-high", 0, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      wa[i] = (i * 87) % PER;
      wb[i] = (i == 0) ? 0 : PER - 1 - i * 83;
      ca[i] = (i * 5) % 64;
      cc[i] = 63 - ca[i];
    end
    wa[NCH-1] = PER - 1; ca[NCH-1] = 63; cc[NCH-1] = 63; wb[NCH-1] = PER - 1;

    repeat (3) @(negedge clk);
    check(pwm_out == '0, "R2 in reset", int'(pwm_out != 0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == '0, "R2 after reset", int'(pwm_out != 0), 0);

    // R1 R5: load while disabled, outputs stay low.
    drive_widths(wa); drive_corrs(ca);
    @(negedge clk); width_load = 1'b0; corr_load = 1'b0;
    repeat (20) @(negedge clk);
    check(pwm_out == '0, "R2 loads while off", int'(pwm_out != 0), 0);

    // R4: enable from disabled; first period at count 0.
    enable_stb = 1'b1;
    @(negedge clk); enable_stb = 1'b0;
    push_exp(wa, ca, "R1/R3");
    measure(0);

    // R5: width load in mid-period waits for the boundary.
    push_exp(wa, ca, "R5 old widths");
    measure(1);
    push_exp(wb, ca, "R5 new widths");
    measure(0);

    // R7: redundant enable does not restart.
    push_exp(wb, ca, "R7");
    measure(2);

    // R5: correction load in mid-period waits for the boundary.
    push_exp(wb, ca, "R5 old corr");
    measure(3);
    push_exp(wb, cc, "R3 new corr");
    measure(0);

    // R8: disable mid-period, with a simultaneous enable.
    repeat (300) @(negedge clk);
    disable_stb = 1'b1; enable_stb = 1'b1;
    @(negedge clk); disable_stb = 1'b0; enable_stb = 1'b0;
    for (int k = 0; k < 50; k++) begin
      check(pwm_out == '0, "R8 disabled", int'(pwm_out != 0), 0);
      @(negedge clk);
    end

    // R4: re-enable restarts the period at the enable.
    enable_stb = 1'b1;
    @(negedge clk); enable_stb = 1'b0;
    push_exp(wb, cc, "R4 restart");
    measure(0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule